// File: doc/BRIEF.md
# Tree Carry-Lookahead Adder

This block adds two unsigned words and a carry input with no clock and no stored state. It delivers the word-wide sum and the unsigned carry out of the top bit. Every bit first forms its own propagate term (A OR B) and generate term (A AND B). These terms are merged pairwise into groups of 2, 4, 8 and so on, up to the full word. The carry input then travels back down the same tree. Each group hands its incoming carry unchanged to its lower half. Its upper half gets the lower half's generate, or the incoming carry gated by the lower half's propagate. This continues until every bit knows its own carry.

The block is meant to be the shared adder inside an execution datapath. To add, drive carry-in low. To subtract B from A, drive B inverted and set carry-in. In that case the carry out is high exactly when A is not below B as an unsigned number. The sum path is built only from AND, OR and XOR gates laid out as the tree. No arithmetic operator is used.

Top module: `cla64_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of opA + opB + carryIn for every input combination.
- R2: `carryOut` equals bit WIDTH (the bit above the word) of opA + opB + carryIn for every input combination.
- R3: With both operands zero and carryIn low, `sumOut` is zero and `carryOut` is low.
- R4: With both operands all ones and carryIn high, `sumOut` is all ones and `carryOut` is high.
- R5: When opB is the bitwise inverse of opA, every bit propagates and no bit generates. `carryOut` then equals carryIn, and `sumOut` is all ones when carryIn is low and all zeros when it is high.
- R6: With opB driven as the inverse of a subtrahend S and carryIn high, `sumOut` equals opA minus S modulo 2^WIDTH. `carryOut` is high exactly when opA is greater than or equal to S, unsigned.
- R7: When no bit position has both operand bits set and carryIn is low, `sumOut` equals opA XOR opB and `carryOut` is low.
- R8: Bit 0 of `sumOut` equals opA[0] XOR opB[0] XOR carryIn.
- R9: The outputs follow the inputs within the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand (inverted by the user for subtraction) |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Unsigned carry out of the top bit |

## Verification
Zero operands and all-ones operands with carry set show whether the tree's root terms and carry-in wiring agree at the two extremes. Complementary operands force every bit to propagate and no bit to generate, so the carry has to cross every level of the downward sweep untouched. Disjoint operands force nothing to generate, which shows whether a stray carry is ever created. Single generating bits placed at each power-of-two position, together with subtraction pairs around equality, exercise each merge boundary and the borrow sense of the carry out. Seeded random operands, compared with a 65-bit reference sum, cover the mixed cases.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned DEFAULT_WIDTH = 64;

  // propagate / generate pair describing one group of bits
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;

endpackage

// File: rtl/cla_leaf_pg.sv
module cla_leaf_pg
  import cla_pkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  output pgPair_t leafPg
);

  // a bit passes a carry on if either input is set, creates one if both are
  assign leafPg.prop = aBit | bBit;
  assign leafPg.gen  = aBit & bBit;

endmodule

// File: rtl/cla_group_merge.sv
module cla_group_merge
  import cla_pkg::*;
(
  input  pgPair_t lowPg,
  input  pgPair_t highPg,
  output pgPair_t groupPg
);

  // upward sweep: fuse two adjacent groups into one twice as wide
  assign groupPg.prop = lowPg.prop & highPg.prop;
  assign groupPg.gen  = highPg.gen | (lowPg.gen & highPg.prop);

endmodule

// File: rtl/cla_carry_split.sv
module cla_carry_split
  import cla_pkg::*;
(
  input  logic    groupCarry,
  input  pgPair_t lowPg,
  output logic    lowCarry,
  output logic    highCarry
);

  // downward sweep: lower half inherits the carry, upper half sees the
  // carry as it leaves the lower half
  assign lowCarry  = groupCarry;
  assign highCarry = lowPg.gen | (groupCarry & lowPg.prop);

endmodule

// File: rtl/cla64_adder.sv
module cla64_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
)(
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  // Heap-numbered tree: node 1 is the whole word, node n has children
  // 2n (lower bits) and 2n+1 (upper bits), node WIDTH+i is bit i.
  // WIDTH must be a power of two.
  localparam int unsigned NODES = 2 * WIDTH;

  logic [NODES-1:1] nodeProp;
  logic [NODES-1:1] nodeGen;
  logic [NODES-1:1] nodeCarry;

  // single-bit terms
  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    pgPair_t leafPg;
    cla_leaf_pg u_leaf (
      .aBit   (opA[i]),
      .bBit   (opB[i]),
      .leafPg (leafPg)
    );
    assign nodeProp[WIDTH+i] = leafPg.prop;
    assign nodeGen[WIDTH+i]  = leafPg.gen;
  end

  // group terms and carry distribution for every internal node
  for (genvar n = 1; n < WIDTH; n++) begin : g_node
    pgPair_t lowPg;
    pgPair_t highPg;
    pgPair_t mergedPg;

    assign lowPg  = '{prop: nodeProp[2*n],   gen: nodeGen[2*n]};
    assign highPg = '{prop: nodeProp[2*n+1], gen: nodeGen[2*n+1]};

    cla_group_merge u_merge (
      .lowPg   (lowPg),
      .highPg  (highPg),
      .groupPg (mergedPg)
    );
    assign nodeProp[n] = mergedPg.prop;
    assign nodeGen[n]  = mergedPg.gen;

    cla_carry_split u_split (
      .groupCarry (nodeCarry[n]),
      .lowPg      (lowPg),
      .lowCarry   (nodeCarry[2*n]),
      .highCarry  (nodeCarry[2*n+1])
    );
  end

  // carry into the whole word
  assign nodeCarry[1] = carryIn;

  // per-bit sum from the leaf carries
  assign sumOut   = opA ^ opB ^ nodeCarry[NODES-1:WIDTH];

  // carry leaving the full-width group
  assign carryOut = nodeGen[1] | (carryIn & nodeProp[1]);

endmodule

// File: rtl/cla64_adder_chk.sv
module cla64_adder_chk #(
  parameter int unsigned WIDTH = 64
)(
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);

  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    // R1
    sum_match_chk: assert (sumOut == refSum[WIDTH-1:0]);
    // R2
    carry_match_chk: assert (carryOut == refSum[WIDTH]);
    // R5
    if (opB == ~opA) begin
      full_propagate_chk: assert (carryOut == carryIn && sumOut == {WIDTH{~carryIn}});
    end
    // R7
    if ((opA & opB) == '0 && !carryIn) begin
      no_generate_chk: assert (!carryOut && sumOut == (opA ^ opB));
    end
    // R8
    low_bit_chk: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn));
  end

endmodule

bind cla64_adder cla64_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/cla64_adder_tb_top.sv
module cla64_adder_tb_top;

  localparam int unsigned W = 64;

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checkCount = 0;
  int failCount  = 0;

  always #2 clk = ~clk;

  cla64_adder #(.WIDTH(W)) dut_i (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(negedge clk);
    opA = a;
    opB = b;
    carryIn = c;
    #1;
  endtask

  task automatic expectVal(input string req, input logic [W:0] actual, input logic [W:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h c=%b)", req, actual, expected, opA, opB, carryIn);
    end
  endtask

  // compare against a 65-bit reference sum; R1 for sum, R2 for carry
  task automatic checkRef(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] ref65;
    drive(a, b, c);
    ref65 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    expectVal("R1", {1'b0, sumOut}, {1'b0, ref65[W-1:0]});
    expectVal("R2", {W'(0), carryOut}, {W'(0), ref65[W]});
  endtask

  task automatic testZero;
    drive('0, '0, 1'b0);
    expectVal("R3", {carryOut, sumOut}, '0);
  endtask

  task automatic testAllOnes;
    drive('1, '1, 1'b1);
    expectVal("R4", {carryOut, sumOut}, {1'b1, {W{1'b1}}});
  endtask

  task automatic testPropagate;
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] a;
      a = {$urandom, $urandom};
      drive(a, ~a, 1'b0);
      expectVal("R5", {carryOut, sumOut}, {1'b0, {W{1'b1}}});
      drive(a, ~a, 1'b1);
      expectVal("R5", {carryOut, sumOut}, {1'b1, {W{1'b0}}});
    end
  endtask

  task automatic testSubtract;
    logic [W-1:0] aList [4];
    logic [W-1:0] sList [4];
    aList = '{64'd100, 64'd5, 64'h8000_0000_0000_0000, 64'd0};
    sList = '{64'd100, 64'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1};
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] diff;
      diff = aList[k] - sList[k];
      drive(aList[k], ~sList[k], 1'b1);
      expectVal("R6", {carryOut, sumOut}, {(aList[k] >= sList[k]), diff});
    end
  endtask

  task automatic testDisjoint;
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom} & ~a;
      drive(a, b, 1'b0);
      expectVal("R7", {carryOut, sumOut}, {1'b0, a ^ b});
    end
  endtask

  task automatic testLowBit;
    for (int k = 0; k < 8; k++) begin
      logic a0;
      logic b0;
      logic c0;
      a0 = k[0];
      b0 = k[1];
      c0 = k[2];
      drive({{(W-1){1'b0}}, a0}, {{(W-1){1'b0}}, b0}, c0);
      expectVal("R8", {W'(0), sumOut[0]}, {W'(0), a0 ^ b0 ^ c0});
    end
  endtask

  // a generated carry at each group boundary must ripple through the tree
  task automatic testBoundaries;
    for (int p = 0; p < W; p = (p == 0) ? 1 : p * 2) begin
      logic [W-1:0] a;
      a = '1 << p;
      checkRef(a, W'(1) << p, 1'b0);
      checkRef(~(W'(1) << p), W'(1), 1'b0);
    end
  endtask

  // outputs must settle in the same cycle the inputs change
  task automatic testSameCycle;
    @(negedge clk);
    opA = 64'd7;
    opB = 64'd9;
    carryIn = 1'b0;
    #0.5;
    expectVal("R9", {carryOut, sumOut}, {1'b0, 64'd16});
  endtask

  task automatic testRandom;
    for (int k = 0; k < 200; k++) begin
      checkRef({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    testZero();
    testAllOnes();
    testPropagate();
    testSubtract();
    testDisjoint();
    testLowBit();
    testBoundaries();
    testSameCycle();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule